// File: doc/BRIEF.md
# Rectangular Blit Address Sequencer

This block walks the addresses of a rectangular copy inside a byte-addressed frame buffer. Software loads a window size, a source byte offset, a destination byte offset and a split pitch into staging registers. It then writes a control word that has the start bit set. For every pixel the block issues one read request at the source address and then one write request at the destination address. It steps pixel by pixel along a row and then moves on to the next row. Combining the pixel data is left to a separate datapath that consumes these requests.

A task can be queued while another is running. A start issued during a transfer captures the staging registers and the control word into a single waiting slot, which raises `full`. When the running task completes, the walker picks up the waiting task on the same clock edge and `full` falls. Control writes that carry no start bit still update the pause and interrupt-enable flags. A control write with the abort bit set discards both the running task and the waiting task.

The walker state machine has four states. IDLE goes to LOAD when a task is loaded. LOAD goes to READ when the window is non-empty. If the window is empty, LOAD completes at once: it goes back to LOAD when another task is ready, and to IDLE otherwise. READ goes to WRITE when the read request is accepted. WRITE goes to READ when the write is accepted and pixels remain. When the last write is accepted, WRITE goes to LOAD if another task is ready and to IDLE otherwise. An abort forces IDLE from any state.

Top module: `blit_addr_seq`

## Requirements
- R1: While reset is active and on the first cycle after it, `busy`, `full`, `req_valid` and `irq` are all 0.
- R2: Register writes use `wr_idx` 0 for control, 1 for window (width in bits 15:0, height in bits 31:16), 2 for source offset, 3 for destination offset and 4 for pitch. Each pixel gives a read (`req_we`=0) at the source address followed by a write (`req_we`=1) at the destination address. Addresses advance by the bytes per pixel taken from control bits 11:10 (0→1, 1→2, 2→3, 3→4).
- R3: A new row starts at the previous row's start plus pitch bits 31:16 for the destination, and plus pitch bits 15:0 for the source.
- R4: With control bit 5 set, addresses within a row decrease by the bytes per pixel.
- R5: With control bit 6 set, both pitch parts are subtracted at each row change.
- R6: With control bit 7 set, the source pitch is ignored: the first source address of each row is the last source address of the previous row plus one pixel step.
- R7: A window whose width or height is zero produces no request, and `busy` is high for exactly one cycle.
- R8: A start while `busy` with `full`=0 queues the task and sets `full`. A start while `full`=1 is ignored. On completion the queued task runs next and `full` clears.
- R9: A control write with bit 30 set makes `busy` and `full` 0 on the next cycle, and no request of either task follows.
- R10: While the most recent control write had bit 27 set, no request is issued and the walk is held. Clearing the bit resumes the walk where it stopped.
- R11: `irq` is 1 when (bit 29 of the last control write is set and `busy`=0) or (bit 28 of the last control write is set and `full`=0).
- R12: A request that is not accepted (`req_ready`=0) keeps its address on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index |
| wr_data | input | 32 | Register write data |
| req_valid | output | 1 | Memory request valid |
| req_we | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | ADDR_W | Byte address of the request |
| req_ready | input | 1 | Memory accepts the request this cycle |
| busy | output | 1 | A task is running |
| full | output | 1 | The waiting task slot is occupied |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect on the clock edge during which it is presented. `irq`, `full` and the pause flag therefore change one cycle after the write, and `busy` rises on that same cycle. The first request of a started task appears one cycle later, after the LOAD state. An abort drops `busy` and `full` one cycle after the write. An empty window keeps `busy` high for a single cycle. The bench drives its inputs on falling edges and records each handshake shortly before the rising edge that completes it. It compares the recorded request list with a stepping model derived from the requirements, so the checks do not depend on how many stalls occurred.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int CTL_HDIR    = 5;
    localparam int CTL_VDIR    = 6;
    localparam int CTL_LINEAR  = 7;
    localparam int CTL_BPP_LO  = 10;
    localparam int CTL_PAUSE   = 27;
    localparam int CTL_IE_ROOM = 28;
    localparam int CTL_IE_IDLE = 29;
    localparam int CTL_ABORT   = 30;
    localparam int CTL_START   = 31;

    localparam int DIM_W = 16;

    localparam logic [2:0] RI_CTRL  = 3'd0;
    localparam logic [2:0] RI_WIN   = 3'd1;
    localparam logic [2:0] RI_SRC   = 3'd2;
    localparam logic [2:0] RI_DST   = 3'd3;
    localparam logic [2:0] RI_PITCH = 3'd4;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_LOAD,
        WS_READ,
        WS_WRITE
    } walk_state_t;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] win;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] pitch;
    } blit_task_t;
endpackage

// File: rtl/blit_addr_step.sv
module blit_addr_step #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] s_cur,
    input  logic [ADDR_W-1:0] d_cur,
    input  logic [ADDR_W-1:0] s_row,
    input  logic [ADDR_W-1:0] d_row,
    input  logic              hdir,
    input  logic              vdir,
    input  logic              linear,
    input  logic [1:0]        bpp,
    input  logic [15:0]       s_pitch,
    input  logic [15:0]       d_pitch,
    output logic [ADDR_W-1:0] s_px,
    output logic [ADDR_W-1:0] d_px,
    output logic [ADDR_W-1:0] s_nrow,
    output logic [ADDR_W-1:0] d_nrow
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] sp;
    logic [ADDR_W-1:0] dp;

    always_comb begin
        step = ADDR_W'(bpp) + ADDR_W'(1);
        sp   = ADDR_W'(s_pitch);
        dp   = ADDR_W'(d_pitch);
        s_px = hdir ? (s_cur - step) : (s_cur + step);
        d_px = hdir ? (d_cur - step) : (d_cur + step);
        d_nrow = vdir ? (d_row - dp) : (d_row + dp);
        if (linear)
            s_nrow = s_px;
        else
            s_nrow = vdir ? (s_row - sp) : (s_row + sp);
    end
endmodule

// File: rtl/blit_task_regs.sv
module blit_task_regs
    import blit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        take,
    input  logic        busy,
    output logic        abort,
    output logic        pause,
    output logic        load_valid,
    output blit_task_t  load_task,
    output logic        full,
    output logic        irq
);
    logic [31:0] stg_win;
    logic [31:0] stg_src;
    logic [31:0] stg_dst;
    logic [31:0] stg_pitch;
    logic [31:0] ctrl_live;
    blit_task_t  queued;
    blit_task_t  new_task;
    logic        ctrl_wr;
    logic        start_req;

    always_comb begin
        ctrl_wr   = wr_en && (wr_idx == RI_CTRL);
        abort     = ctrl_wr && wr_data[CTL_ABORT];
        start_req = ctrl_wr && wr_data[CTL_START] && !wr_data[CTL_ABORT];
        new_task.ctrl  = wr_data;
        new_task.win   = stg_win;
        new_task.src   = stg_src;
        new_task.dst   = stg_dst;
        new_task.pitch = stg_pitch;
        load_valid = full || start_req;
        load_task  = full ? queued : new_task;
        pause      = ctrl_live[CTL_PAUSE];
        irq        = (ctrl_live[CTL_IE_IDLE] && !busy) ||
                     (ctrl_live[CTL_IE_ROOM] && !full);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_win   <= '0;
            stg_src   <= '0;
            stg_dst   <= '0;
            stg_pitch <= '0;
            ctrl_live <= '0;
        end else if (wr_en) begin
            unique case (wr_idx)
                RI_CTRL:  ctrl_live <= wr_data;
                RI_WIN:   stg_win   <= wr_data;
                RI_SRC:   stg_src   <= wr_data;
                RI_DST:   stg_dst   <= wr_data;
                RI_PITCH: stg_pitch <= wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            queued <= '0;
        end else if (abort) begin
            full <= 1'b0;
        end else if (take && full) begin
            full <= 1'b0;
        end else if (start_req && !full && !take) begin
            queued <= new_task;
            full   <= 1'b1;
        end
    end

    // R8
    full_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> busy);

    // R8
    full_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && start_req && !take |=> full);
endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              pause,
    input  logic              load_valid,
    input  blit_task_t        load_task,
    output logic              take,
    output logic              req_valid,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_ready,
    output logic              busy
);
    walk_state_t state;
    walk_state_t nxt;

    logic [31:0]       act_ctrl;
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
    logic [15:0]       s_pitch;
    logic [15:0]       d_pitch;
    logic [ADDR_W-1:0] s_cur;
    logic [ADDR_W-1:0] d_cur;
    logic [ADDR_W-1:0] s_row;
    logic [ADDR_W-1:0] d_row;
    logic [DIM_W-1:0]  col;
    logic [DIM_W-1:0]  row;
    logic [ADDR_W-1:0] s_px;
    logic [ADDR_W-1:0] d_px;
    logic [ADDR_W-1:0] s_nrow;
    logic [ADDR_W-1:0] d_nrow;

    logic fire;
    logic last_col;
    logic last_row;
    logic zero_win;
    logic done_now;
    logic load;

    blit_addr_step #(.ADDR_W(ADDR_W)) step_i (
        .s_cur   (s_cur),
        .d_cur   (d_cur),
        .s_row   (s_row),
        .d_row   (d_row),
        .hdir    (act_ctrl[CTL_HDIR]),
        .vdir    (act_ctrl[CTL_VDIR]),
        .linear  (act_ctrl[CTL_LINEAR]),
        .bpp     (act_ctrl[CTL_BPP_LO+1:CTL_BPP_LO]),
        .s_pitch (s_pitch),
        .d_pitch (d_pitch),
        .s_px    (s_px),
        .d_px    (d_px),
        .s_nrow  (s_nrow),
        .d_nrow  (d_nrow)
    );

    // Outputs and completion decode
    always_comb begin
        busy      = (state != WS_IDLE);
        req_valid = !pause && (state == WS_READ || state == WS_WRITE);
        req_we    = (state == WS_WRITE);
        req_addr  = (state == WS_WRITE) ? d_cur : s_cur;
        fire      = req_valid && req_ready;
        last_col  = (col == width - DIM_W'(1));
        last_row  = (row == height - DIM_W'(1));
        zero_win  = (width == '0) || (height == '0);
        done_now  = (state == WS_LOAD && zero_win) ||
                    (state == WS_WRITE && fire && last_col && last_row);
        take      = !abort && (state == WS_IDLE || done_now);
        load      = take && load_valid;
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            WS_IDLE:  nxt = load ? WS_LOAD : WS_IDLE;
            WS_LOAD:  nxt = zero_win ? (load ? WS_LOAD : WS_IDLE) : WS_READ;
            WS_READ:  nxt = fire ? WS_WRITE : WS_READ;
            WS_WRITE: begin
                if (!fire)
                    nxt = WS_WRITE;
                else if (last_col && last_row)
                    nxt = load ? WS_LOAD : WS_IDLE;
                else
                    nxt = WS_READ;
            end
            default:  nxt = WS_IDLE;
        endcase
        if (abort)
            nxt = WS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= WS_IDLE;
        else
            state <= nxt;
    end

    // Task capture and address stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ctrl <= '0;
            width    <= '0;
            height   <= '0;
            s_pitch  <= '0;
            d_pitch  <= '0;
            s_cur    <= '0;
            d_cur    <= '0;
            s_row    <= '0;
            d_row    <= '0;
            col      <= '0;
            row      <= '0;
        end else if (load) begin
            act_ctrl <= load_task.ctrl;
            width    <= load_task.win[DIM_W-1:0];
            height   <= load_task.win[31:16];
            s_pitch  <= load_task.pitch[15:0];
            d_pitch  <= load_task.pitch[31:16];
            s_cur    <= ADDR_W'(load_task.src);
            d_cur    <= ADDR_W'(load_task.dst);
            s_row    <= ADDR_W'(load_task.src);
            d_row    <= ADDR_W'(load_task.dst);
            col      <= '0;
            row      <= '0;
        end else if (!abort && state == WS_WRITE && fire) begin
            if (!last_col) begin
                s_cur <= s_px;
                d_cur <= d_px;
                col   <= col + DIM_W'(1);
            end else if (!last_row) begin
                s_cur <= s_nrow;
                s_row <= s_nrow;
                d_cur <= d_nrow;
                d_row <= d_nrow;
                col   <= '0;
                row   <= row + DIM_W'(1);
            end
        end
    end

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !abort |=> $stable(req_addr) && $stable(req_we));

    // R10
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause && !abort && (state == WS_READ || state == WS_WRITE)
        |=> $stable(s_cur) && $stable(d_cur));

    // R2
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_READ || state == WS_WRITE) |-> (col < width) && (row < height));
endmodule

// File: rtl/blit_addr_seq.sv
module blit_addr_seq
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [31:0]       wr_data,
    output logic              req_valid,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_ready,
    output logic              busy,
    output logic              full,
    output logic              irq
);
    logic       take;
    logic       abort;
    logic       pause;
    logic       load_valid;
    blit_task_t load_task;

    blit_task_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .take       (take),
        .busy       (busy),
        .abort      (abort),
        .pause      (pause),
        .load_valid (load_valid),
        .load_task  (load_task),
        .full       (full),
        .irq        (irq)
    );

    blit_walker #(.ADDR_W(ADDR_W)) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (abort),
        .pause      (pause),
        .load_valid (load_valid),
        .load_task  (load_task),
        .take       (take),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .busy       (busy)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid && !full);
endmodule

// File: tb/blit_addr_seq_tb.sv
module blit_addr_seq_tb_top;
    localparam int ADDR_W = 24;
    localparam int NV = 6;

    logic clk;
    logic rst_n;
    logic wr_en;
    logic [2:0] wr_idx;
    logic [31:0] wr_data;
    logic req_valid;
    logic req_we;
    logic [ADDR_W-1:0] req_addr;
    logic req_ready;
    logic busy;
    logic full;
    logic irq;
    logic stall;

    int checks = 0;
    int errors = 0;

    logic [31:0] log_addr [256];
    logic        log_we   [256];
    int          log_n = 0;
    logic [31:0] exp_addr [256];
    logic        exp_we   [256];
    int          exp_n = 0;

    // Stimulus table: control, window, source, destination, pitch, stall, request count
    localparam logic [31:0] V_CTRL  [NV] = '{32'h8000_0000, 32'h8000_0C00, 32'h8000_0420,
                                             32'h8000_0040, 32'h8000_0880, 32'h8000_0C60};
    localparam logic [31:0] V_WIN   [NV] = '{32'h0002_0003, 32'h0002_0002, 32'h0001_0003,
                                             32'h0003_0001, 32'h0002_0002, 32'h0002_0002};
    localparam logic [31:0] V_SRC   [NV] = '{32'h100, 32'h1000, 32'h300, 32'h500, 32'h10, 32'h4000};
    localparam logic [31:0] V_DST   [NV] = '{32'h800, 32'h2000, 32'h400, 32'h900, 32'h2000, 32'h6000};
    localparam logic [31:0] V_PITCH [NV] = '{32'h0040_0020, 32'h0100_0080, 32'h0,
                                             32'h0010_0008, 32'h0100_0100, 32'h0020_0010};
    localparam logic        V_STALL [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam int          V_NREQ  [NV] = '{12, 8, 6, 6, 8, 8};

    blit_addr_seq #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_ready(req_ready),
        .busy(busy), .full(full), .irq(irq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    initial begin
        req_ready = 1'b1;
        forever begin
            @(posedge clk);
            #2;
            req_ready = stall ? ~req_ready : 1'b1;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (req_valid && req_ready && log_n < 256) begin
                log_addr[log_n] = 32'(req_addr);
                log_we[log_n]   = req_we;
                log_n++;
            end
        end
    end

    function automatic string vtag(int i);
        case (i)
            0: return "R2 R3";
            1: return "R2 R12";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R4 R5 R12";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        int g = 0;
        while (busy && g < 3000) begin
            @(negedge clk);
            g++;
        end
        chk(!busy, req, 32'(busy), 32'h0);
    endtask

    // Expected request list from the stepping rules (appends to exp lists)
    task automatic model(input logic [31:0] c, input logic [31:0] w, input logic [31:0] s,
                         input logic [31:0] d, input logic [31:0] p);
        logic [31:0] st = 32'(c[11:10]) + 1;
        logic [31:0] sr = s;
        logic [31:0] dr = d;
        logic [31:0] sa;
        logic [31:0] da;
        for (int r = 0; r < int'(w[31:16]); r++) begin
            sa = sr; da = dr;
            for (int k = 0; k < int'(w[15:0]); k++) begin
                exp_addr[exp_n] = sa & 32'h00FF_FFFF; exp_we[exp_n] = 1'b0; exp_n++;
                exp_addr[exp_n] = da & 32'h00FF_FFFF; exp_we[exp_n] = 1'b1; exp_n++;
                if (k < int'(w[15:0]) - 1) begin
                    sa = c[5] ? sa - st : sa + st;
                    da = c[5] ? da - st : da + st;
                end
            end
            dr = c[6] ? dr - 32'(p[31:16]) : dr + 32'(p[31:16]);
            if (c[7]) sr = c[5] ? sa - st : sa + st;
            else      sr = c[6] ? sr - 32'(p[15:0]) : sr + 32'(p[15:0]);
        end
    endtask

    task automatic cmp_log(input string req, input int first);
        int bad = 0;
        int at = -1;
        for (int i = 0; i < exp_n; i++) begin
            if (first + i >= log_n || log_addr[first+i] != exp_addr[i] || log_we[first+i] != exp_we[i]) begin
                bad++;
                if (at < 0) at = i;
            end
        end
        if (at < 0) at = 0;
        chk(bad == 0, req, log_addr[first+at], exp_addr[at]);
    endtask

    task automatic load_regs(input logic [31:0] w, input logic [31:0] s,
                             input logic [31:0] d, input logic [31:0] p);
        wr(3'd1, w); wr(3'd2, s); wr(3'd3, d); wr(3'd4, p);
    endtask

    initial begin
        int cnt;
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; stall = 1'b0;
        cyc(3);
        // R1: reset state
        chk(!busy && !full && !req_valid && !irq, "R1 in reset",
            {28'h0, busy, full, req_valid, irq}, 32'h0);
        rst_n = 1'b1;
        cyc(1);
        chk(!busy && !full && !req_valid && !irq, "R1 after reset",
            {28'h0, busy, full, req_valid, irq}, 32'h0);

        // Table walk: R2 R3 R4 R5 R6 R12
        for (int v = 0; v < NV; v++) begin
            stall = V_STALL[v];
            load_regs(V_WIN[v], V_SRC[v], V_DST[v], V_PITCH[v]);
            log_n = 0; exp_n = 0;
            wr(3'd0, V_CTRL[v]);
            wait_idle(vtag(v));
            cyc(2);
            chk(log_n == V_NREQ[v], vtag(v), 32'(log_n), 32'(V_NREQ[v]));
            model(V_CTRL[v], V_WIN[v], V_SRC[v], V_DST[v], V_PITCH[v]);
            cmp_log(vtag(v), 0);
        end
        stall = 1'b0;
        cyc(2);

        // R7: zero width and zero height
        load_regs(32'h0001_0000, 32'h10, 32'h20, 32'h0);
        log_n = 0;
        wr(3'd0, 32'h8000_0000);
        chk(busy, "R7 busy one cycle", 32'(busy), 32'h1);
        cyc(1);
        chk(!busy, "R7 zero width done", 32'(busy), 32'h0);
        wr(3'd1, 32'h0000_0005);
        wr(3'd0, 32'h8000_0000);
        cyc(2);
        chk(!busy && log_n == 0, "R7 no requests", 32'(log_n), 32'h0);

        // R8: queue one task, ignore a third start
        load_regs(32'h0001_0008, 32'h0, 32'h100, 32'h0);
        log_n = 0; exp_n = 0;
        wr(3'd0, 32'h8000_0000);
        wr(3'd1, 32'h0001_0002); wr(3'd2, 32'h40); wr(3'd3, 32'h200);
        wr(3'd0, 32'h8000_0400);
        chk(full && busy, "R8 queued sets full", 32'(full), 32'h1);
        wr(3'd0, 32'h8000_0000);
        chk(full, "R8 start ignored while full", 32'(full), 32'h1);
        wait_idle("R8");
        cyc(2);
        chk(log_n == 16 + 4, "R8 request count", 32'(log_n), 32'd20);
        chk(!full, "R8 full cleared", 32'(full), 32'h0);
        model(32'h8000_0000, 32'h0001_0008, 32'h0, 32'h100, 32'h0);
        model(32'h8000_0400, 32'h0001_0002, 32'h40, 32'h200, 32'h0);
        cmp_log("R8 order", 0);

        // R9: abort running and queued
        load_regs(32'h0008_0008, 32'h0, 32'h1000, 32'h0010_0010);
        log_n = 0;
        wr(3'd0, 32'h8000_0000);
        wr(3'd0, 32'h8000_0000);
        chk(full, "R9 setup queued", 32'(full), 32'h1);
        cyc(3);
        wr(3'd0, 32'h4000_0000);
        chk(!busy && !full, "R9 abort clears", {30'h0, busy, full}, 32'h0);
        cnt = log_n;
        cyc(6);
        chk(log_n == cnt && !busy, "R9 no requests after abort", 32'(log_n), 32'(cnt));

        // R10: pause holds then resumes
        load_regs(32'h0001_0002, 32'h80, 32'h300, 32'h0);
        log_n = 0; exp_n = 0;
        wr(3'd0, 32'h8800_0000);
        cyc(6);
        chk(log_n == 0 && busy, "R10 paused", 32'(log_n), 32'h0);
        wr(3'd0, 32'h0000_0000);
        wait_idle("R10");
        cyc(2);
        chk(log_n == 4, "R10 resumed count", 32'(log_n), 32'd4);
        model(32'h8000_0000, 32'h0001_0002, 32'h80, 32'h300, 32'h0);
        cmp_log("R10 resumed order", 0);

        // R11: interrupt conditions
        wr(3'd0, 32'h2000_0000);
        chk(irq, "R11 idle interrupt", 32'(irq), 32'h1);
        wr(3'd0, 32'h1000_0000);
        chk(irq, "R11 room interrupt", 32'(irq), 32'h1);
        wr(3'd0, 32'h0000_0000);
        chk(!irq, "R11 disabled", 32'(irq), 32'h0);
        load_regs(32'h0008_0008, 32'h0, 32'h0, 32'h0);
        wr(3'd0, 32'hA000_0000);
        chk(!irq && busy, "R11 idle irq low while busy", 32'(irq), 32'h0);
        wr(3'd0, 32'h4000_0000);
        wr(3'd0, 32'h9000_0000);
        chk(irq, "R11 room irq while not full", 32'(irq), 32'h1);
        wr(3'd0, 32'h9000_0000);
        chk(!irq && full, "R11 room irq low when full", 32'(irq), 32'h0);
        wr(3'd0, 32'h4000_0000);
        cyc(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule